// File: doc/BRIEF.md
# Lane Frame Restorer and Sample Unpacker

This block sits behind the 8b/10b decoder of one serial lane that has already reached character alignment. Each accepted octet arrives with a flag that says whether it was a control character. A sync input marks the octet that opens a multiframe. From that point the block counts octets and frames, so that every octet has a known place in its frame and every frame has a known place in its multiframe.

When scrambling is off, the transmitter sends a control character instead of a frame's closing octet whenever that octet would repeat the previous frame's closing octet. It does the same at multiframe ends, using a different character. This can also happen with scrambling on, only less often. The block always puts the repeated octet back, whichever mode the link is in.

Each restored frame of eight octets is cut into five 12-bit samples. The four tail bits are dropped, and one valid-qualified sample vector comes out per frame, with a start-of-multiframe flag and an error flag. Non-zero tail bits set a sticky diagnostic bit.

Top module: `frame_restore`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `out_valid`, `out_som`, `out_err` and `tail_err` are low, and the stored previous frame-end octet is 0x00.
- R2: An octet accepted (`in_valid` high) with `in_sync` high is octet 0 of frame 0 of a multiframe. No frame is produced before the first such octet. A later `in_sync` restarts the count and discards any partly collected frame.
- R3: After sync, each group of 8 accepted octets forms one frame. `out_valid` is high for exactly one cycle, in the cycle after the 8th octet is accepted. Cycles with `in_valid` low are skipped.
- R4: With the frame taken as a 64-bit word whose octet 0 is bits 63:56, sample i (i = 0 to 4) is word bits 63-12i down to 52-12i. It appears on `out_samples[12i+11:12i]`.
- R5: `out_som` is high together with `out_valid` only for the first of every 4 frames after sync, which is frame index 0.
- R6: An octet 0xFC with `in_ctrl` high, in octet position 7, is replaced by the stored previous frame-end octet.
- R7: An octet 0x7C with `in_ctrl` high, in octet position 7 of frame index 3, is replaced by the stored previous frame-end octet.
- R8: At every frame end the stored previous frame-end octet takes the restored value of octet 7. When a frame-end substitute arrives before any frame has ended, the value it restores is 0x00.
- R9: An octet 0xFC or 0x7C with `in_ctrl` high in positions 0 to 6, or 0x7C with `in_ctrl` high in position 7 of frame index 0 to 2, passes through unchanged. It raises `out_err` together with that frame's `out_valid`.
- R10: The 4 tail bits (word bits 3:0) do not appear in `out_samples`. A frame with non-zero tail bits sets `tail_err`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Octet accepted this cycle |
| in_data | input | 8 | Decoded octet |
| in_ctrl | input | 1 | Octet is a control character |
| in_sync | input | 1 | Octet opens a multiframe |
| out_valid | output | 1 | Frame sample vector valid |
| out_samples | output | 60 | Five 12-bit samples, sample 0 in the low bits |
| out_som | output | 1 | Frame is first of its multiframe |
| out_err | output | 1 | Misplaced alignment character in this frame |
| tail_err | output | 1 | Sticky: a frame had non-zero tail bits |

## Verification
Two functions can act in the same cycle. At octet 7, substitution supplies the very octet that the tail check inspects. Within a single frame, a misplaced alignment character can raise the error flag while the frame end is still restored correctly. The bench drives frames that combine an early 0xFC control octet with a legitimate frame-end substitute, and frames whose restored end octet carries non-zero tail bits. A reference model built from the requirements predicts the restored samples, the error flag and the sticky tail bit for these frames.

// File: rtl/frame_restore_pkg.sv
package frame_restore_pkg;

    localparam int OCTET_W = 8;

    localparam logic [OCTET_W-1:0] FRAME_ALIGN_CHAR = 8'hFC;
    localparam logic [OCTET_W-1:0] MF_ALIGN_CHAR    = 8'h7C;

    typedef enum logic [1:0] {
        CH_DATA        = 2'd0,
        CH_FRAME_ALIGN = 2'd1,
        CH_MF_ALIGN    = 2'd2
    } char_kind_e;

    typedef struct packed {
        logic [OCTET_W-1:0] data;
        logic               err;
    } restored_t;

    function automatic char_kind_e classify_octet(input logic ctrl,
                                                  input logic [OCTET_W-1:0] d);
        if (!ctrl)                  return CH_DATA;
        if (d == FRAME_ALIGN_CHAR)  return CH_FRAME_ALIGN;
        if (d == MF_ALIGN_CHAR)     return CH_MF_ALIGN;
        return CH_DATA;
    endfunction

endpackage

// File: rtl/frame_tracker.sv
module frame_tracker #(
    parameter int OCTETS_PER_FRAME = 8,
    parameter int FRAMES_PER_MF    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_sync,
    output logic active,
    output logic frame_start,
    output logic frame_end,
    output logic mf_start,
    output logic mf_end
);
    localparam int OCT_IDX_W = (OCTETS_PER_FRAME > 1) ? $clog2(OCTETS_PER_FRAME) : 1;
    localparam int FRM_IDX_W = (FRAMES_PER_MF > 1) ? $clog2(FRAMES_PER_MF) : 1;
    localparam logic [OCT_IDX_W-1:0] LAST_OCT = OCT_IDX_W'(OCTETS_PER_FRAME - 1);
    localparam logic [FRM_IDX_W-1:0] LAST_FRM = FRM_IDX_W'(FRAMES_PER_MF - 1);

    logic                 locked_q;
    logic [OCT_IDX_W-1:0] oct_q, cur_oct;
    logic [FRM_IDX_W-1:0] frm_q, cur_frm;

    always_comb begin
        cur_oct     = in_sync ? '0 : oct_q;
        cur_frm     = in_sync ? '0 : frm_q;
        active      = in_valid & (in_sync | locked_q);
        frame_start = (cur_oct == '0);
        frame_end   = (cur_oct == LAST_OCT);
        mf_start    = (cur_frm == '0);
        mf_end      = (cur_frm == LAST_FRM);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q <= 1'b0;
            oct_q    <= '0;
            frm_q    <= '0;
        end else if (active) begin
            locked_q <= 1'b1;
            if (frame_end) begin
                oct_q <= '0;
                frm_q <= mf_end ? '0 : cur_frm + 1'b1;
            end else begin
                oct_q <= cur_oct + 1'b1;
                frm_q <= cur_frm;
            end
        end
    end

endmodule

// File: rtl/align_restorer.sv
module align_restorer
    import frame_restore_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               active,
    input  logic               frame_end,
    input  logic               mf_end,
    input  logic               in_ctrl,
    input  logic [OCTET_W-1:0] in_data,
    output restored_t          restored
);
    logic [OCTET_W-1:0] last_end_q;
    char_kind_e         kind;

    always_comb begin
        kind          = classify_octet(in_ctrl, in_data);
        restored.data = in_data;
        restored.err  = 1'b0;
        unique case (kind)
            CH_FRAME_ALIGN: begin
                if (frame_end) restored.data = last_end_q;
                else           restored.err  = 1'b1;
            end
            CH_MF_ALIGN: begin
                if (frame_end && mf_end) restored.data = last_end_q;
                else                     restored.err  = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_end_q <= '0;
        end else if (active && frame_end) begin
            last_end_q <= restored.data;
        end
    end

endmodule

// File: rtl/frame_unpacker.sv
module frame_unpacker
    import frame_restore_pkg::*;
#(
    parameter int OCTETS_PER_FRAME = 8,
    parameter int SAMPLE_W         = 12,
    parameter int NUM_SAMPLES      = 5
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            active,
    input  logic                            frame_start,
    input  logic                            frame_end,
    input  logic                            mf_start,
    input  restored_t                       restored,
    output logic                            out_valid,
    output logic [NUM_SAMPLES*SAMPLE_W-1:0] out_samples,
    output logic                            out_som,
    output logic                            out_err,
    output logic                            tail_err
);
    localparam int FRAME_W = OCTETS_PER_FRAME * OCTET_W;
    localparam int ACC_W   = FRAME_W - OCTET_W;
    localparam int TAIL_W  = FRAME_W - NUM_SAMPLES * SAMPLE_W;

    logic [ACC_W-1:0]                acc_q;
    logic                            err_acc_q;
    logic                            som_q;
    logic [FRAME_W-1:0]              frame_word;
    logic [NUM_SAMPLES*SAMPLE_W-1:0] samples_d;
    logic                            tail_bad;

    assign frame_word = {acc_q, restored.data};

    for (genvar i = 0; i < NUM_SAMPLES; i++) begin : g_slice
        assign samples_d[i*SAMPLE_W +: SAMPLE_W] =
            frame_word[FRAME_W-1-i*SAMPLE_W -: SAMPLE_W];
    end

    if (TAIL_W > 0) begin : g_tail
        assign tail_bad = |frame_word[TAIL_W-1:0];
    end else begin : g_no_tail
        assign tail_bad = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            err_acc_q <= 1'b0;
            som_q     <= 1'b0;
        end else if (active) begin
            acc_q <= {acc_q[ACC_W-OCTET_W-1:0], restored.data};
            if (frame_start) begin
                err_acc_q <= restored.err;
                som_q     <= mf_start;
            end else begin
                err_acc_q <= err_acc_q | restored.err;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_samples <= '0;
            out_som     <= 1'b0;
            out_err     <= 1'b0;
            tail_err    <= 1'b0;
        end else begin
            out_valid <= active && frame_end;
            out_som   <= active && frame_end && som_q;
            out_err   <= active && frame_end && (err_acc_q | restored.err);
            if (active && frame_end) begin
                out_samples <= samples_d;
                if (tail_bad) tail_err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/frame_restore.sv
module frame_restore
    import frame_restore_pkg::*;
#(
    parameter int OCTETS_PER_FRAME = 8,
    parameter int FRAMES_PER_MF    = 4,
    parameter int SAMPLE_W         = 12,
    parameter int NUM_SAMPLES      = 5
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            in_valid,
    input  logic [7:0]                      in_data,
    input  logic                            in_ctrl,
    input  logic                            in_sync,
    output logic                            out_valid,
    output logic [NUM_SAMPLES*SAMPLE_W-1:0] out_samples,
    output logic                            out_som,
    output logic                            out_err,
    output logic                            tail_err
);
    logic      active, frame_start, frame_end, mf_start, mf_end;
    restored_t restored;

    frame_tracker #(
        .OCTETS_PER_FRAME(OCTETS_PER_FRAME),
        .FRAMES_PER_MF   (FRAMES_PER_MF)
    ) tracker_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sync    (in_sync),
        .active     (active),
        .frame_start(frame_start),
        .frame_end  (frame_end),
        .mf_start   (mf_start),
        .mf_end     (mf_end)
    );

    align_restorer restorer_i (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .frame_end(frame_end),
        .mf_end   (mf_end),
        .in_ctrl  (in_ctrl),
        .in_data  (in_data),
        .restored (restored)
    );

    frame_unpacker #(
        .OCTETS_PER_FRAME(OCTETS_PER_FRAME),
        .SAMPLE_W        (SAMPLE_W),
        .NUM_SAMPLES     (NUM_SAMPLES)
    ) unpacker_i (
        .clk        (clk),
        .rst        (rst),
        .active     (active),
        .frame_start(frame_start),
        .frame_end  (frame_end),
        .mf_start   (mf_start),
        .restored   (restored),
        .out_valid  (out_valid),
        .out_samples(out_samples),
        .out_som    (out_som),
        .out_err    (out_err),
        .tail_err   (tail_err)
    );

endmodule

// File: rtl/frame_restore_chk.sv
module frame_restore_chk (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_sync,
    input logic out_valid,
    input logic out_som,
    input logic out_err,
    input logic tail_err
);
    logic seen_sync_q;

    always_ff @(posedge clk) begin
        if (rst)                      seen_sync_q <= 1'b0;
        else if (in_valid && in_sync) seen_sync_q <= 1'b1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_som && !out_err && !tail_err));

    // R2
    sync_first_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> seen_sync_q);

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R3
    follows_input_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R5
    som_qualified_chk: assert property (@(posedge clk) disable iff (rst)
        out_som |-> out_valid);

    // R9
    err_qualified_chk: assert property (@(posedge clk) disable iff (rst)
        out_err |-> out_valid);

    // R10
    tail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        tail_err |=> tail_err);

endmodule

bind frame_restore frame_restore_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_sync  (in_sync),
    .out_valid(out_valid),
    .out_som  (out_som),
    .out_err  (out_err),
    .tail_err (tail_err)
);

// File: tb/frame_restore_tb_top.sv
module frame_restore_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ctrl = 1'b0;
    logic        in_sync = 1'b0;
    logic        out_valid;
    logic [59:0] out_samples;
    logic        out_som;
    logic        out_err;
    logic        tail_err;

    always #4 clk = ~clk;

    frame_restore dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ctrl(in_ctrl), .in_sync(in_sync), .out_valid(out_valid),
        .out_samples(out_samples), .out_som(out_som), .out_err(out_err),
        .tail_err(tail_err)
    );

    typedef struct {
        logic [59:0] samples;
        logic        som;
        logic        err;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   n_out = 0;
    bit   done = 0;

    // reference model state
    logic [7:0]  m_last = 8'h00;
    logic [55:0] m_acc = '0;
    int          m_pos = 0;
    int          m_frm = 0;
    bit          m_locked = 0;
    bit          m_err = 0;
    bit          m_som = 0;
    int          seed = 7;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [59:0] to_samples(input logic [63:0] w);
        logic [59:0] s;
        for (int i = 0; i < 5; i++) s[i*12 +: 12] = w[63-12*i -: 12];
        return s;
    endfunction

    task automatic send(input logic [7:0] d, input logic c, input logic s, input string tag);
        logic [7:0] r;
        bit         e;
        exp_t       x;
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_ctrl = c; in_sync = s;
        if (s) begin m_pos = 0; m_frm = 0; m_locked = 1; end
        if (m_locked) begin
            r = d; e = 0;
            if (c && d == 8'hFC) begin
                if (m_pos == 7) r = m_last; else e = 1;
            end else if (c && d == 8'h7C) begin
                if (m_pos == 7 && m_frm == 3) r = m_last; else e = 1;
            end
            if (m_pos == 0) begin m_err = e; m_som = (m_frm == 0); end
            else m_err = m_err | e;
            if (m_pos == 7) begin
                x.samples = to_samples({m_acc, r});
                x.som = m_som; x.err = m_err; x.tag = tag;
                q.push_back(x);
                m_last = r;
                m_pos = 0;
                m_frm = (m_frm + 1) % 4;
            end else begin
                m_acc = {m_acc[47:0], r};
                m_pos++;
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_sync = 1'b0; in_ctrl = 1'b0;
        end
    endtask

    // ctrl mask bit 7 belongs to octet 0
    task automatic send_frame(input logic [63:0] w, input logic [7:0] cm,
                              input logic first_sync, input int gap, input string tag);
        for (int i = 0; i < 8; i++) begin
            send(w[63-8*i -: 8], cm[7-i], (i == 0) && first_sync, tag);
            if (gap > 0) idle(gap);
        end
    endtask

    function automatic logic [63:0] gen_word();
        logic [63:0] w;
        for (int i = 0; i < 8; i++) begin
            seed = (seed * 37 + 11) % 251;
            w[8*i +: 8] = seed[7:0];
        end
        w[3:0] = 4'h0;
        return w;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; in_sync = 1'b0; in_ctrl = 1'b0;
        m_last = 8'h00; m_locked = 0; m_pos = 0; m_frm = 0;
        idle(2);
        chk("R1 out_valid in reset", {63'd0, out_valid}, 64'd0);
        chk("R1 tail_err in reset", {63'd0, tail_err}, 64'd0);
        chk("R1 som/err in reset", {62'd0, out_som, out_err}, 64'd0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 outputs after release", {60'd0, out_valid, out_som, out_err, tail_err}, 64'd0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            n_out++;
            if (q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R3 unexpected out_valid actual=1 expected=0");
            end else begin
                exp_t x;
                x = q.pop_front();
                chk({x.tag, " samples"}, {4'h0, out_samples}, {4'h0, x.samples});
                chk({"R5 som ", x.tag}, {63'd0, out_som}, {63'd0, x.som});
                chk({"R9 err ", x.tag}, {63'd0, out_err}, {63'd0, x.err});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        do_reset();

        // R2: octets before any sync produce nothing
        for (int i = 0; i < 12; i++) send(8'(i * 19), (i == 7), 1'b0, "R2 pre-sync");
        idle(3);
        chk("R2 no frames before sync", 64'(n_out), 64'd0);

        // R8: first frame-end substitute restores 0x00; R6 substitution
        send_frame(64'h1234_5678_9ABC_DEFC, 8'h01, 1'b1, 0, "R8 initial substitute");
        // R3 R4 R5: plain frames, back to back and with gaps
        send_frame(gen_word(), 8'h00, 1'b0, 0, "R4 plain");
        send_frame(gen_word(), 8'h00, 1'b0, 2, "R3 gapped");
        send_frame(64'hA5A5_0F0F_3C3C_7710, 8'h00, 1'b0, 0, "R4 frame3");
        // next multiframe: R6 at frame 1, R7 at frame 3
        send_frame(gen_word(), 8'h00, 1'b0, 1, "R5 mf start");
        send_frame(64'hFFFF_FFFF_0000_00FC, 8'h01, 1'b0, 0, "R6 frame-end substitute");
        send_frame(64'h0123_4567_89AB_CD80, 8'h00, 1'b0, 0, "R8 update");
        send_frame(64'h1111_2222_3333_447C, 8'h01, 1'b0, 0, "R7 multiframe-end substitute");
        idle(2);
        chk("R10 tail_err clear on zero tails", {63'd0, tail_err}, 64'd0);

        // R2: resync in the middle of a frame discards the partial frame
        send(8'h55, 1'b0, 1'b0, "R2 partial");
        send(8'h66, 1'b0, 1'b0, "R2 partial");
        send(8'h77, 1'b0, 1'b0, "R2 partial");
        send_frame(64'hCAFE_BABE_0123_4560, 8'h00, 1'b1, 0, "R2 resync");

        // R9 + R6 in one frame: early FC and a valid end substitute
        send_frame(64'h1020_FC40_5060_70FC, 8'h21, 1'b0, 0, "R9 early FC with end FC");
        idle(2);
        chk("R10 tail_err still clear", {63'd0, tail_err}, 64'd0);

        // R10: non-zero tail sets sticky bit, samples unaffected
        send_frame(64'h89AB_CDEF_0123_4535, 8'h00, 1'b0, 0, "R10 tail nonzero");
        idle(1);
        chk("R10 tail_err set", {63'd0, tail_err}, 64'd1);
        // substitute restores 0x35 (non-zero tail) at multiframe end
        send_frame(64'h0000_1111_2222_33FC, 8'h01, 1'b0, 0, "R10 substitute carries tail");
        // R9: 7C at end of frame 0 passes through, error raised
        send_frame(64'h1357_9BDF_2468_AC7C, 8'h01, 1'b0, 0, "R9 misplaced 7C");
        send_frame(gen_word(), 8'h00, 1'b0, 0, "R10 clean after");
        idle(2);
        chk("R10 tail_err sticky", {63'd0, tail_err}, 64'd1);

        idle(4);
        chk("R3 all frames delivered", 64'(q.size()), 64'd0);

        // R1: second reset clears sticky bit and previous end octet
        do_reset();
        send_frame(64'h4242_4242_4242_42FC, 8'h01, 1'b1, 0, "R1 end octet cleared");
        idle(4);
        chk("R3 queue empty at end", 64'(q.size()), 64'd0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule